// File: doc/BRIEF.md
# Six-Stage Pipeline Hazard and Bypass Controller

This block is the hazard-control unit for an in-order pipeline with the stages IF, ID, EX, M1, M2 and WB. ALU instructions write the register file through a second write port at the end of EX, while loads write at the end of WB. The controller looks at the destination, valid bit and kind of the instructions in EX, M1, M2 and WB, and at the two source registers of the instruction in ID. It then picks an operand source for each source register, raises a stall for ID, and produces squash and trap-redirect controls when M2 reports a memory address fault.

Because an ALU result is already in the register file once its producer has moved on to M1, only the instruction right behind an ALU producer needs a forwarded ALU result. Load data still has to be forwarded from M2 and WB. To keep faults precise, an ALU instruction is never allowed to enter EX directly behind a load or store. That ALU instruction therefore reaches EX no earlier than the cycle in which the memory instruction's fault status is known in M2, and it can be suppressed there. The outputs are combinational. The clock and reset feed only the built-in checks.

Top module: `hzc_ctrl`

## Requirements
- R1: Kind codes are 0 ALU, 1 load, 2 store, 3 other, and operand select codes are 0 register file, 1 EX ALU result, 2 M2 load data, 3 WB load data. When the youngest matching writer of a source register is a valid ALU instruction in EX, that operand's select is 1.
- R2: When the youngest matching writer is a valid ALU instruction in M1, M2 or WB, the select is 0 and there is no stall.
- R3: When the youngest matching writer is a valid load in M2, the select is 2. When it is a valid load in WB, the select is 3.
- R4: When the youngest matching writer of either source is a valid load in EX or M1, stall_id is 1 (load-use interlock).
- R5: A valid ALU instruction in ID with a valid load or store in EX is stalled, whether or not the two depend on each other. Non-ALU kinds in ID are not stalled by this rule.
- R6: Register 0 never matches. A source of 0 always selects 0 and never causes a stall, and a destination of 0 never forwards.
- R7: Only kinds ALU and load count as writers. Among several writers of the same register, the one in the youngest stage (EX before M1 before M2 before WB) decides the select and the stall.
- R8: A fault flag from a valid load or store in M2 raises trap_req and all four kill outputs (IF, ID, EX, M1) in the same cycle, and forces stall_id to 0.
- R9: alu_wr_en is 1 exactly when EX holds a valid ALU instruction with a non-zero destination and no trap is being raised.
- R10: The fault flag is ignored when M2 is invalid or holds an ALU or other kind. In that case no trap and no kill is produced.
- R11: When ID is not valid, stall_id is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the built-in checks |
| rst | input | 1 | Synchronous active-high reset for the checks |
| id_valid | input | 1 | ID holds an instruction |
| id_kind | input | 2 | Kind of the ID instruction |
| id_rs1 | input | REG_AW | First source register in ID |
| id_rs2 | input | REG_AW | Second source register in ID |
| ex_valid | input | 1 | EX holds an instruction |
| ex_kind | input | 2 | Kind in EX |
| ex_rd | input | REG_AW | Destination in EX |
| m1_valid | input | 1 | M1 holds an instruction |
| m1_kind | input | 2 | Kind in M1 |
| m1_rd | input | REG_AW | Destination in M1 |
| m2_valid | input | 1 | M2 holds an instruction |
| m2_kind | input | 2 | Kind in M2 |
| m2_rd | input | REG_AW | Destination in M2 |
| m2_fault | input | 1 | Address fault reported for the M2 instruction |
| wb_valid | input | 1 | WB holds an instruction |
| wb_kind | input | 2 | Kind in WB |
| wb_rd | input | REG_AW | Destination in WB |
| src_sel_a | output | 2 | Operand source for id_rs1 |
| src_sel_b | output | 2 | Operand source for id_rs2 |
| stall_id | output | 1 | Hold ID and insert a bubble into EX |
| kill_if | output | 1 | Squash IF |
| kill_id | output | 1 | Squash ID |
| kill_ex | output | 1 | Squash EX |
| kill_m1 | output | 1 | Squash M1 |
| trap_req | output | 1 | Request a redirect to the trap handler |
| alu_wr_en | output | 1 | Enable for the EX-stage register write port |

## Verification
The checks that run on every cycle cover these properties: a trap always kills every younger stage, forces the stall low and blocks the EX write port; a fault flag is honoured only for memory kinds; register 0 never forwards; an idle ID never stalls; an ALU instruction directly behind a memory instruction always stalls; and the EX and M2 selects are issued only when a matching producer is really in that stage. Youngest-first priority needs the bench's scenarios, because only a reference model can show which of several writers must win. The same holds for the exact mapping from each stage and kind to a select or a stall, and for the absence of a stall on non-dependent non-ALU instructions.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    typedef enum logic [1:0] {
        K_ALU   = 2'd0,
        K_LOAD  = 2'd1,
        K_STORE = 2'd2,
        K_OTHER = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        SEL_RF     = 2'd0,
        SEL_EX_ALU = 2'd1,
        SEL_M2_LD  = 2'd2,
        SEL_WB_LD  = 2'd3
    } src_sel_e;

    // Producer positions behind ID, youngest first
    localparam int unsigned POS_EX = 0;
    localparam int unsigned POS_M1 = 1;
    localparam int unsigned POS_M2 = 2;
    localparam int unsigned POS_WB = 3;
    localparam int unsigned N_PROD = 4;
    localparam int unsigned N_SRC  = 2;

    typedef struct packed {
        src_sel_e sel;
        logic     stall;
    } fwd_t;

    function automatic logic is_mem(op_kind_e k);
        return (k == K_LOAD) || (k == K_STORE);
    endfunction

    function automatic logic writes_reg(op_kind_e k);
        return (k == K_ALU) || (k == K_LOAD);
    endfunction

    // Decision for the youngest matching writer found at position pos
    function automatic fwd_t classify_hit(int unsigned pos, op_kind_e k);
        fwd_t r;
        r.sel   = SEL_RF;
        r.stall = 1'b0;
        if (k == K_ALU) begin
            if (pos == POS_EX) r.sel = SEL_EX_ALU;
        end else begin
            case (pos)
                POS_EX, POS_M1: r.stall = 1'b1;
                POS_M2:         r.sel   = SEL_M2_LD;
                default:        r.sel   = SEL_WB_LD;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/hzc_operand_resolve.sv
module hzc_operand_resolve
    import hzc_pkg::*;
#(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned NPROD  = N_PROD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPROD-1:0]  p_valid,
    input  op_kind_e          p_kind [NPROD],
    input  logic [REG_AW-1:0] p_rd   [NPROD],
    input  logic [REG_AW-1:0] rs,
    output src_sel_e          sel,
    output logic              dep_stall
);

    logic [NPROD-1:0] hit;

    for (genvar g = 0; g < NPROD; g++) begin : g_match
        assign hit[g] = p_valid[g] && writes_reg(p_kind[g]) &&
                        (p_rd[g] == rs) && (rs != '0);
    end

    always_comb begin
        fwd_t res;
        logic found;
        res   = '{sel: SEL_RF, stall: 1'b0};
        found = 1'b0;
        for (int i = 0; i < NPROD; i++) begin
            if (!found && hit[i]) begin
                found = 1'b1;
                res   = classify_hit(i, p_kind[i]);
            end
        end
        sel       = res.sel;
        dep_stall = res.stall;
    end

    assert_ex_src_real_R1: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_EX_ALU) |-> (p_valid[POS_EX] && p_kind[POS_EX] == K_ALU &&
                                 p_rd[POS_EX] == rs && rs != '0));

    assert_m2_src_real_R3: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_M2_LD) |-> (p_valid[POS_M2] && p_kind[POS_M2] == K_LOAD &&
                                p_rd[POS_M2] == rs));

    assert_zero_src_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (rs == '0) |-> (sel == SEL_RF && !dep_stall));

endmodule

// File: rtl/hzc_interlock.sv
module hzc_interlock
    import hzc_pkg::*;
#(
    parameter int unsigned NSRC = N_SRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            id_valid,
    input  op_kind_e        id_kind,
    input  logic            ex_valid,
    input  op_kind_e        ex_kind,
    input  logic [NSRC-1:0] dep_stall,
    input  logic            trap,
    output logic            stall_id
);

    logic mem_then_alu;

    assign mem_then_alu = (id_kind == K_ALU) && ex_valid && is_mem(ex_kind);
    assign stall_id     = id_valid && !trap && ((|dep_stall) || mem_then_alu);

    assert_idle_id_R11: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> !stall_id);

    assert_mem_alu_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (id_valid && id_kind == K_ALU && ex_valid && ex_kind == K_STORE && !trap)
        |-> stall_id);

endmodule

// File: rtl/hzc_trap_ctl.sv
module hzc_trap_ctl
    import hzc_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m2_valid,
    input  op_kind_e          m2_kind,
    input  logic              m2_fault,
    input  logic              ex_valid,
    input  op_kind_e          ex_kind,
    input  logic [REG_AW-1:0] ex_rd,
    output logic              trap,
    output logic [3:0]        kill_vec,
    output logic              alu_wr_en
);

    assign trap      = m2_valid && is_mem(m2_kind) && m2_fault;
    assign kill_vec  = {4{trap}};
    assign alu_wr_en = ex_valid && (ex_kind == K_ALU) && (ex_rd != '0) && !trap;

    assert_fault_filter_R10: assert property (@(posedge clk) disable iff (rst)
        (!m2_valid || m2_kind == K_ALU || m2_kind == K_OTHER) |-> !trap);

    assert_trap_blocks_write_R9: assert property (@(posedge clk) disable iff (rst)
        trap |-> !alu_wr_en);

endmodule

// File: rtl/hzc_ctrl.sv
module hzc_ctrl
    import hzc_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid,
    input  logic [1:0]        id_kind,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              ex_valid,
    input  logic [1:0]        ex_kind,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              m1_valid,
    input  logic [1:0]        m1_kind,
    input  logic [REG_AW-1:0] m1_rd,
    input  logic              m2_valid,
    input  logic [1:0]        m2_kind,
    input  logic [REG_AW-1:0] m2_rd,
    input  logic              m2_fault,
    input  logic              wb_valid,
    input  logic [1:0]        wb_kind,
    input  logic [REG_AW-1:0] wb_rd,
    output logic [1:0]        src_sel_a,
    output logic [1:0]        src_sel_b,
    output logic              stall_id,
    output logic              kill_if,
    output logic              kill_id,
    output logic              kill_ex,
    output logic              kill_m1,
    output logic              trap_req,
    output logic              alu_wr_en
);

    logic [N_PROD-1:0] p_valid;
    op_kind_e          p_kind [N_PROD];
    logic [REG_AW-1:0] p_rd   [N_PROD];
    logic [REG_AW-1:0] rs_arr [N_SRC];
    src_sel_e          sel_arr[N_SRC];
    logic [N_SRC-1:0]  dep_vec;
    logic              trap;
    logic [3:0]        kill_vec;

    assign p_valid = {wb_valid, m2_valid, m1_valid, ex_valid};
    assign p_kind[POS_EX] = op_kind_e'(ex_kind);
    assign p_kind[POS_M1] = op_kind_e'(m1_kind);
    assign p_kind[POS_M2] = op_kind_e'(m2_kind);
    assign p_kind[POS_WB] = op_kind_e'(wb_kind);
    assign p_rd[POS_EX]   = ex_rd;
    assign p_rd[POS_M1]   = m1_rd;
    assign p_rd[POS_M2]   = m2_rd;
    assign p_rd[POS_WB]   = wb_rd;
    assign rs_arr[0]      = id_rs1;
    assign rs_arr[1]      = id_rs2;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        hzc_operand_resolve #(.REG_AW(REG_AW), .NPROD(N_PROD)) u_res (
            .clk       (clk),
            .rst       (rst),
            .p_valid   (p_valid),
            .p_kind    (p_kind),
            .p_rd      (p_rd),
            .rs        (rs_arr[s]),
            .sel       (sel_arr[s]),
            .dep_stall (dep_vec[s])
        );
    end

    hzc_trap_ctl #(.REG_AW(REG_AW)) u_trap (
        .clk       (clk),
        .rst       (rst),
        .m2_valid  (m2_valid),
        .m2_kind   (op_kind_e'(m2_kind)),
        .m2_fault  (m2_fault),
        .ex_valid  (ex_valid),
        .ex_kind   (op_kind_e'(ex_kind)),
        .ex_rd     (ex_rd),
        .trap      (trap),
        .kill_vec  (kill_vec),
        .alu_wr_en (alu_wr_en)
    );

    hzc_interlock #(.NSRC(N_SRC)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .id_valid  (id_valid),
        .id_kind   (op_kind_e'(id_kind)),
        .ex_valid  (ex_valid),
        .ex_kind   (op_kind_e'(ex_kind)),
        .dep_stall (dep_vec),
        .trap      (trap),
        .stall_id  (stall_id)
    );

    assign src_sel_a = sel_arr[0];
    assign src_sel_b = sel_arr[1];
    assign trap_req  = trap;
    assign kill_if   = kill_vec[3];
    assign kill_id   = kill_vec[2];
    assign kill_ex   = kill_vec[1];
    assign kill_m1   = kill_vec[0];

    assert_trap_kills_all_R8: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (kill_if && kill_id && kill_ex && kill_m1 && !stall_id));

    assert_load_ex_dep_R4: assert property (@(posedge clk) disable iff (rst)
        (id_valid && !trap_req && ex_valid && ex_kind == 2'd1 &&
         ex_rd == id_rs1 && id_rs1 != '0) |-> stall_id);

    assert_mem_alu_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (id_valid && id_kind == 2'd0 && ex_valid && ex_kind == 2'd1 && !trap_req)
        |-> stall_id);

    assert_alu_write_ok_R9: assert property (@(posedge clk) disable iff (rst)
        alu_wr_en |-> (ex_valid && ex_kind == 2'd0 && ex_rd != '0));

endmodule

// File: tb/hzc_ctrl_test.sv
module hzc_ctrl_test;

    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          id_valid;
    logic [1:0]    id_kind;
    logic [AW-1:0] id_rs1, id_rs2;
    logic [3:0]    sv;
    logic [1:0]    sk [4];
    logic [AW-1:0] sr [4];
    logic          m2_fault;

    logic [1:0] src_sel_a, src_sel_b;
    logic stall_id, kill_if, kill_id, kill_ex, kill_m1, trap_req, alu_wr_en;

    int n_cmp = 0;
    int n_bad = 0;

    hzc_ctrl #(.REG_AW(AW)) uut (
        .clk(clk), .rst(rst),
        .id_valid(id_valid), .id_kind(id_kind), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_valid(sv[0]), .ex_kind(sk[0]), .ex_rd(sr[0]),
        .m1_valid(sv[1]), .m1_kind(sk[1]), .m1_rd(sr[1]),
        .m2_valid(sv[2]), .m2_kind(sk[2]), .m2_rd(sr[2]), .m2_fault(m2_fault),
        .wb_valid(sv[3]), .wb_kind(sk[3]), .wb_rd(sr[3]),
        .src_sel_a(src_sel_a), .src_sel_b(src_sel_b), .stall_id(stall_id),
        .kill_if(kill_if), .kill_id(kill_id), .kill_ex(kill_ex), .kill_m1(kill_m1),
        .trap_req(trap_req), .alu_wr_en(alu_wr_en)
    );

    // Reference: scan stages youngest first, first ALU/load writer decides
    function automatic void ref_src(input logic [AW-1:0] rs,
                                    output int sel, output int st);
        bit done = 0;
        sel = 0; st = 0;
        for (int i = 0; i < 4; i++) begin
            if (!done && rs != 0 && sv[i] && (sk[i] == 2'd0 || sk[i] == 2'd1)
                && sr[i] == rs) begin
                done = 1;
                if (sk[i] == 2'd0) sel = (i == 0) ? 1 : 0;
                else if (i <= 1) st = 1;
                else sel = (i == 2) ? 2 : 3;
            end
        end
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic verify(string tag);
        int sa, sb, da, db, trp, stl, wr;
        ref_src(id_rs1, sa, da);
        ref_src(id_rs2, sb, db);
        trp = (sv[2] && (sk[2] == 2'd1 || sk[2] == 2'd2) && m2_fault) ? 1 : 0;
        stl = (id_valid && !trp && (da || db ||
               (id_kind == 2'd0 && sv[0] && (sk[0] == 2'd1 || sk[0] == 2'd2)))) ? 1 : 0;
        wr  = (sv[0] && sk[0] == 2'd0 && sr[0] != 0 && !trp) ? 1 : 0;
        chk(tag, "sel_a", int'(src_sel_a), sa);
        chk(tag, "sel_b", int'(src_sel_b), sb);
        chk(tag, "stall", int'(stall_id), stl);
        chk(tag, "trap", int'(trap_req), trp);
        chk(tag, "kills", int'({kill_if, kill_id, kill_ex, kill_m1}), trp ? 15 : 0);
        chk(tag, "wr_en", int'(alu_wr_en), wr);
    endtask

    task automatic clear_all();
        id_valid = 0; id_kind = 0; id_rs1 = 0; id_rs2 = 0; m2_fault = 0;
        sv = 0;
        for (int i = 0; i < 4; i++) begin sk[i] = 2'd3; sr[i] = 0; end
    endtask

    task automatic step(string tag);
        @(negedge clk);
        #2;
        verify(tag);
    endtask

    initial begin
        clear_all();
        repeat (3) @(posedge clk);
        #1;
        // reset-time outputs with everything idle
        chk("R11", "reset sel_a", int'(src_sel_a), 0);
        chk("R11", "reset stall", int'(stall_id), 0);
        chk("R8", "reset trap", int'(trap_req), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: ALU in EX feeds next instruction
        clear_all(); id_valid = 1; id_kind = 0; id_rs1 = 5; id_rs2 = 6;
        sv[0] = 1; sk[0] = 0; sr[0] = 5;
        step("R1");
        chk("R1", "direct sel_a", int'(src_sel_a), 1);

        // R2: ALU in M1 already in file
        clear_all(); id_valid = 1; id_kind = 0; id_rs2 = 7;
        sv[1] = 1; sk[1] = 0; sr[1] = 7;
        step("R2");
        chk("R2", "direct sel_b", int'(src_sel_b), 0);

        // R3: load in M2 and load in WB
        clear_all(); id_valid = 1; id_kind = 0; id_rs1 = 3; id_rs2 = 4;
        sv[2] = 1; sk[2] = 1; sr[2] = 3; sv[3] = 1; sk[3] = 1; sr[3] = 4;
        step("R3");
        chk("R3", "direct sel_a", int'(src_sel_a), 2);
        chk("R3", "direct sel_b", int'(src_sel_b), 3);

        // R4: load-use from M1
        clear_all(); id_valid = 1; id_kind = 2; id_rs1 = 9;
        sv[1] = 1; sk[1] = 1; sr[1] = 9;
        step("R4");
        chk("R4", "direct stall", int'(stall_id), 1);

        // R5: store in EX, independent ALU in ID; then load in ID (no stall)
        clear_all(); id_valid = 1; id_kind = 0; id_rs1 = 1; id_rs2 = 2;
        sv[0] = 1; sk[0] = 2; sr[0] = 8;
        step("R5");
        chk("R5", "direct stall alu", int'(stall_id), 1);
        id_kind = 1;
        step("R5");
        chk("R5", "direct stall load", int'(stall_id), 0);

        // R6: register 0 everywhere
        clear_all(); id_valid = 1; id_kind = 1;
        sv = 4'hF; sk[0] = 1; sk[1] = 1; sk[2] = 1; sk[3] = 0;
        step("R6");
        chk("R6", "direct stall", int'(stall_id), 0);
        chk("R6", "direct wr_en", int'(alu_wr_en), 0);

        // R7: ALU in EX beats load in M2; ALU in M1 beats load in WB; store ignored
        clear_all(); id_valid = 1; id_kind = 3; id_rs1 = 12; id_rs2 = 13;
        sv = 4'hF; sk[0] = 0; sr[0] = 12; sk[1] = 0; sr[1] = 13;
        sk[2] = 1; sr[2] = 12; sk[3] = 1; sr[3] = 13;
        step("R7");
        chk("R7", "direct sel_a", int'(src_sel_a), 1);
        chk("R7", "direct sel_b", int'(src_sel_b), 0);
        sk[0] = 2; sk[1] = 2;
        step("R7");
        chk("R7", "store skip sel_a", int'(src_sel_a), 2);

        // R8/R9: load faults in M2 with ALU in EX
        clear_all(); id_valid = 1; id_kind = 0; id_rs1 = 14;
        sv[0] = 1; sk[0] = 0; sr[0] = 11; sv[1] = 1; sk[1] = 1; sr[1] = 14;
        sv[2] = 1; sk[2] = 1; m2_fault = 1;
        step("R8");
        chk("R8", "direct kill_ex", int'(kill_ex), 1);
        chk("R9", "direct wr_en", int'(alu_wr_en), 0);
        chk("R8", "direct stall", int'(stall_id), 0);

        // R10: fault with ALU or invalid M2 ignored
        sk[2] = 0;
        step("R10");
        chk("R10", "alu m2 trap", int'(trap_req), 0);
        chk("R9", "alu m2 wr_en", int'(alu_wr_en), 1);
        sk[2] = 2; sv[2] = 0;
        step("R10");
        chk("R10", "invalid m2 trap", int'(trap_req), 0);

        // R11: invalid ID with hazards present
        clear_all(); id_valid = 0; id_kind = 0; id_rs1 = 2;
        sv[0] = 1; sk[0] = 1; sr[0] = 2;
        step("R11");
        chk("R11", "direct stall", int'(stall_id), 0);

        // Constrained random mix, small register range for frequent matches
        void'($urandom(32'd2718));
        for (int n = 0; n < 2000; n++) begin
            id_valid = ($urandom_range(0, 7) != 0);
            id_kind  = 2'($urandom_range(0, 3));
            id_rs1   = AW'($urandom_range(0, 3));
            id_rs2   = AW'($urandom_range(0, 3));
            for (int i = 0; i < 4; i++) begin
                sv[i] = ($urandom_range(0, 3) != 0);
                sk[i] = 2'($urandom_range(0, 3));
                sr[i] = AW'($urandom_range(0, 3));
            end
            m2_fault = ($urandom_range(0, 5) == 0);
            step("R1/R2/R3/R4/R5/R6/R7/R8/R9/R10/R11");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule